// File: doc/BRIEF.md
# Masked Level Interrupt Controller

This block collects a bank of level-sensitive interrupt request lines and one separate fast-interrupt line. It presents them to a processor as two request outputs. Software controls the block through a small register window on a simple bus. The bus has an address, write data with a write strobe, and a read strobe that returns registered read data one cycle later. Every register sits at a fixed byte offset from the window base.

Each request line has its own enable bit. Writing ones to the enable-set register turns bits on, and writing ones to the enable-clear register turns them off. Zero bits leave enables alone, so two pieces of software can share the mask without a read-modify-write race. The fast-interrupt enable is handled the same way through its own pair of registers. Nothing is latched. A request stands exactly as long as its input level and its enable are both high.

A read-only register also reports the highest-numbered pending source, so a handler can find a source without scanning the status word.

Top module: `intc_mask_ctrl`

## Requirements
- R1: A read strobe at offset 0x00 returns the request input levels sampled at that clock edge in bits N_SRC-1:0 of rdata_o, one cycle later. rdata_o holds its value in cycles with no read strobe.
- R2: A write to offset 0x0C sets every enable bit whose write-data bit is 1. Bits written 0 keep their value.
- R3: A write to offset 0x10 clears every enable bit whose write-data bit is 1. Bits written 0 keep their value.
- R4: A read at offset 0x08 returns the current enable mask.
- R5: A read at offset 0x04 returns the pending word, which is the input levels ANDed with the enable mask.
- R6: irq_o is high exactly when at least one request input is high with its enable set. It falls as soon as the inputs drop, with no latching.
- R7: fiq_o equals fiq_src_i ANDed with the fast enable. The fast enable is set by writing bit 0 = 1 at offset 0x18 and cleared by writing bit 0 = 1 at offset 0x1C. A read at offset 0x14 returns bit 0 = raw fast input, bit 1 = fiq_o and bit 2 = fast enable.
- R8: Reset clears all enables, so irq_o and fiq_o are low and the enable read returns 0.
- R9: A read at offset 0x20 returns bit 31 = 1 and bits 4:0 = index of the highest-numbered pending source when any source is pending. It returns 0 when none is pending.
- R10: Reads at unmapped offsets and at the write-only offsets 0x0C, 0x10, 0x18 and 0x1C return 0. Writes to read-only or unmapped offsets change no enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| irq_src_i | input | N_SRC | Level-sensitive request lines |
| fiq_src_i | input | 1 | Level-sensitive fast request line |
| addr_i | input | AW | Byte offset from window base |
| wdata_i | input | DW | Write data |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe |
| rdata_o | output | DW | Registered read data |
| irq_o | output | 1 | Combined request to processor |
| fiq_o | output | 1 | Fast request to processor |

## Verification
Some properties are checked by assertions on every cycle:
- an enable word changes only in bits that a set or clear write named;
- a set write leaves its named bits on;
- neither output rises without a matching enable and input;
- the raw read returns the sampled inputs, and read data holds between strobes;
- the priority readout always points at a pending source with nothing pending above it.

Other behaviour can be shown only by the bench scenarios:
- the concrete register offsets, the fast-status bit layout and the zero reads of unmapped offsets;
- the immediate drop of irq_o when inputs fall;
- the fact that writes to read-only offsets leave the mask untouched.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int unsigned OFS_RAW  = 'h00;
  localparam int unsigned OFS_PEND = 'h04;
  localparam int unsigned OFS_EN   = 'h08;
  localparam int unsigned OFS_ESET = 'h0C;
  localparam int unsigned OFS_ECLR = 'h10;
  localparam int unsigned OFS_FSTS = 'h14;
  localparam int unsigned OFS_FSET = 'h18;
  localparam int unsigned OFS_FCLR = 'h1C;
  localparam int unsigned OFS_PRIO = 'h20;
endpackage

// File: rtl/intc_en_bank.sv
module intc_en_bank #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] en_o
);
  logic [W-1:0] en_q;

  // clear wins if both ever arrive together
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_q <= '0;
    else         en_q <= (en_q | set_i) & ~clr_i;
  end

  assign en_o = en_q;

  // R2
  set_sticks_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((|set_i) && !(|clr_i)) |=> ((en_q & $past(set_i)) == $past(set_i)));

  // R3
  clr_sticks_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|clr_i) |=> ((en_q & $past(clr_i)) == '0));

  // R2 R3
  untouched_bits_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((en_q ^ $past(en_q)) & ~($past(set_i) | $past(clr_i))) == '0);
endmodule

// File: rtl/intc_prio.sv
module intc_prio #(
  parameter int unsigned N  = 32,
  parameter int unsigned IW = 5
) (
  input  logic [N-1:0]  pend_i,
  output logic          valid_o,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = 0; i < N; i++) begin
      if (pend_i[i]) idx_o = IW'(i);
    end
  end

  assign valid_o = |pend_i;

  // R9
  always_comb begin
    if (valid_o) begin
      idx_pending_chk: assert (pend_i[idx_o]);
      none_above_chk:  assert (((pend_i >> idx_o) >> 1) == '0);
    end
  end
endmodule

// File: rtl/intc_mask_ctrl.sv
module intc_mask_ctrl
  import intc_pkg::*;
#(
  parameter int unsigned N_SRC = 32,
  parameter int unsigned DW    = 32,
  parameter int unsigned AW    = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] irq_src_i,
  input  logic             fiq_src_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic             wr_en_i,
  input  logic             rd_en_i,
  output logic [DW-1:0]    rdata_o,
  output logic             irq_o,
  output logic             fiq_o
);
  localparam int unsigned IW = (N_SRC > 1) ? $clog2(N_SRC) : 1;
  localparam logic [AW-1:0] A_RAW  = AW'(OFS_RAW);
  localparam logic [AW-1:0] A_PEND = AW'(OFS_PEND);
  localparam logic [AW-1:0] A_EN   = AW'(OFS_EN);
  localparam logic [AW-1:0] A_ESET = AW'(OFS_ESET);
  localparam logic [AW-1:0] A_ECLR = AW'(OFS_ECLR);
  localparam logic [AW-1:0] A_FSTS = AW'(OFS_FSTS);
  localparam logic [AW-1:0] A_FSET = AW'(OFS_FSET);
  localparam logic [AW-1:0] A_FCLR = AW'(OFS_FCLR);
  localparam logic [AW-1:0] A_PRIO = AW'(OFS_PRIO);

  logic [N_SRC-1:0] irq_en, pend, irq_set, irq_clr;
  logic [0:0]       fiq_en, fiq_set, fiq_clr;
  logic             prio_valid;
  logic [IW-1:0]    prio_idx;
  logic [DW-1:0]    rd_nxt, rdata_q;

  assign irq_set = (wr_en_i && addr_i == A_ESET) ? wdata_i[N_SRC-1:0] : '0;
  assign irq_clr = (wr_en_i && addr_i == A_ECLR) ? wdata_i[N_SRC-1:0] : '0;
  assign fiq_set = (wr_en_i && addr_i == A_FSET) ? wdata_i[0] : 1'b0;
  assign fiq_clr = (wr_en_i && addr_i == A_FCLR) ? wdata_i[0] : 1'b0;

  intc_en_bank #(.W(N_SRC)) u_irq_en (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (irq_set),
    .clr_i (irq_clr),
    .en_o  (irq_en)
  );

  intc_en_bank #(.W(1)) u_fiq_en (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (fiq_set),
    .clr_i (fiq_clr),
    .en_o  (fiq_en)
  );

  assign pend  = irq_src_i & irq_en;
  assign irq_o = |pend;
  assign fiq_o = fiq_src_i & fiq_en[0];

  intc_prio #(.N(N_SRC), .IW(IW)) u_prio (
    .pend_i (pend),
    .valid_o(prio_valid),
    .idx_o  (prio_idx)
  );

  always_comb begin
    rd_nxt = '0;
    unique case (addr_i)
      A_RAW:  rd_nxt[N_SRC-1:0] = irq_src_i;
      A_PEND: rd_nxt[N_SRC-1:0] = pend;
      A_EN:   rd_nxt[N_SRC-1:0] = irq_en;
      A_FSTS: rd_nxt[2:0]       = {fiq_en[0], fiq_o, fiq_src_i};
      A_PRIO: begin
        rd_nxt[DW-1]   = prio_valid;
        rd_nxt[IW-1:0] = prio_idx;
      end
      default: rd_nxt = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rdata_q <= '0;
    else if (rd_en_i) rdata_q <= rd_nxt;
  end

  assign rdata_o = rdata_q;

  // R1
  raw_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && addr_i == A_RAW) |=> (rdata_o[N_SRC-1:0] == $past(irq_src_i)));

  // R1
  rdata_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> $stable(rdata_o));

  // R6
  irq_needs_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> ((irq_src_i & irq_en) != '0));

  // R7
  fiq_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fiq_o |-> (fiq_src_i && fiq_en[0]));
endmodule

// File: tb/sim_intc_mask_ctrl.sv
`timescale 1ns/1ps
module sim_intc_mask_ctrl;
  localparam int unsigned N_SRC = 32;
  localparam int unsigned DW = 32;
  localparam int unsigned AW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N_SRC-1:0] irq_src = '0;
  logic fiq_src = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [DW-1:0] rdata;
  logic irq, fiq;
  int total = 0, bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  intc_mask_ctrl #(.N_SRC(N_SRC), .DW(DW), .AW(AW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .irq_src_i(irq_src), .fiq_src_i(fiq_src),
    .addr_i(addr), .wdata_i(wdata), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .rdata_o(rdata), .irq_o(irq), .fiq_o(fiq)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; wdata = '0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    do_reset();
    irq_src = '1; fiq_src = 1'b1;
    @(negedge clk);
    chk("R8 irq_o", {31'b0, irq}, 0);
    chk("R8 fiq_o", {31'b0, fiq}, 0);
    rd(8'h08, d); chk("R8 enable", d, 0);
    irq_src = '0; fiq_src = 1'b0;
  endtask

  task automatic t_raw();
    logic [31:0] d;
    irq_src = 32'hA5A5_0F0F;
    rd(8'h00, d); chk("R1 raw", d, 32'hA5A5_0F0F);
    irq_src = 32'h1234_5678;
    repeat (2) @(negedge clk);
    chk("R1 hold", rdata, 32'hA5A5_0F0F);
  endtask

  task automatic t_set_clr();
    logic [31:0] d;
    wr(8'h0C, 32'h0000_00F0);
    rd(8'h08, d); chk("R2 set", d, 32'h0000_00F0);
    wr(8'h0C, 32'h0000_0F00);
    rd(8'h08, d); chk("R2 zeros keep", d, 32'h0000_0FF0);
    wr(8'h10, 32'h0000_0030);
    rd(8'h08, d); chk("R3 clr", d, 32'h0000_0FC0);
    rd(8'h08, d); chk("R4 readback", d, 32'h0000_0FC0);
  endtask

  task automatic t_pend_irq();
    logic [31:0] d;
    irq_src = 32'h0000_0F0F;
    rd(8'h04, d); chk("R5 pend", d, 32'h0000_0F00);
    chk("R6 irq high", {31'b0, irq}, 1);
    rd(8'h20, d); chk("R9 prio", d, 32'h8000_000B);
    irq_src = 32'h0000_003F;
    #1;
    chk("R6 irq drop", {31'b0, irq}, 0);
    rd(8'h04, d); chk("R6 no latch", d, 0);
    rd(8'h20, d); chk("R9 none", d, 0);
    wr(8'h0C, 32'h8000_0000);
    irq_src = 32'h8000_0040;
    rd(8'h20, d); chk("R9 top", d, 32'h8000_001F);
    irq_src = '0;
  endtask

  task automatic t_fiq();
    logic [31:0] d;
    fiq_src = 1'b1;
    #1;
    chk("R7 fiq masked", {31'b0, fiq}, 0);
    rd(8'h14, d); chk("R7 sts off", d, 32'h1);
    wr(8'h18, 32'h1);
    chk("R7 fiq on", {31'b0, fiq}, 1);
    chk("R7 irq indep", {31'b0, irq}, 0);
    rd(8'h14, d); chk("R7 sts on", d, 32'h7);
    wr(8'h1C, 32'hFFFF_FFFE);
    chk("R7 clr zero", {31'b0, fiq}, 1);
    fiq_src = 1'b0;
    #1;
    chk("R7 level", {31'b0, fiq}, 0);
    wr(8'h1C, 32'h1);
    rd(8'h14, d); chk("R7 sts clr", d, 0);
  endtask

  task automatic t_unmapped();
    logic [31:0] d;
    rd(8'h08, d);
    chk("R10 pre", d, 32'h8000_0FC0);
    wr(8'h00, 32'hFFFF_FFFF);
    wr(8'h3C, 32'hFFFF_FFFF);
    wr(8'h08, 32'hFFFF_FFFF);
    rd(8'h08, d); chk("R10 ro write", d, 32'h8000_0FC0);
    rd(8'h3C, d); chk("R10 unmapped", d, 0);
    rd(8'h0C, d); chk("R10 wo read", d, 0);
    do_reset();
    rd(8'h08, d); chk("R8 re-reset", d, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_raw();
    t_set_clr();
    t_pend_irq();
    t_fiq();
    t_unmapped();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog act=hung exp=done");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule